// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from a parameterized set of peripheral sources and offers a single request to the processor. Each source keeps a pending flag, an enable bit and a 3-bit priority chosen by software. Among the sources that are both enabled and pending, the one with the highest priority wins. When several share that priority, the one with the lowest index wins. The winner is offered to the processor only when its priority is strictly above the processor's current 4-bit level and the global enable is on. The winning vector number and its priority are latched into a status register, which drives the vector and level outputs.

The processor side has three controls. The acknowledge input moves the current level to the latched level and reports the previous level so the processor can stack it. The return input reloads the level from a value the processor supplies. A nesting-disable control makes every acknowledge raise the level to at least 7. Software reaches the flags, enables, priorities, control bits, level and status through a word-wide register port with a write strobe and a combinational read path.

Top module: `prio_irq_ctrl`

## Requirements
- R1: The pending flag of source k is set by a high `src_req[k]` and stays set until software writes 1 to bit k at address 0. If a hardware request and a software clear of the same bit fall in one cycle, the flag ends set.
- R2: The enable register is at address 2, with bit k belonging to source k. A source whose enable bit is 0 never wins arbitration, whatever its flag or priority.
- R3: The priority of source k is held in bits [4*(k%8)+2 : 4*(k%8)] of the register at address 3 + k/8. Bit 3 of each nibble reads as 0.
- R4: Among enabled pending sources, the highest priority wins. On a tie, the lowest source index wins.
- R5: The vector number of source k is k + 8. When a request is raised, `irq_vec` and `irq_lvl` hold the winner's vector and priority. The same pair reads at address 10 as {level in [11:8], vector in [7:0]}.
- R6: `irq_req` rises only when the winning priority is strictly greater than `cpu_lvl`. A source with priority 0 never raises a request.
- R7: Bit 0 of the control register at address 8 is a global enable. While it is 0, `irq_req` stays low.
- R8: Software writes at address 9 load only bits [2:0] of `cpu_lvl`, and bit 3 keeps its value. The level reads back at address 9.
- R9: On `irq_ack`, `saved_lvl` takes the old `cpu_lvl`, `cpu_lvl` takes the latched level, and `irq_req` is low in the next cycle.
- R10: With bit 1 of the control register set (nesting disabled), an acknowledge sets `cpu_lvl` to 7 when the latched level is below 7.
- R11: On `irq_ret` without `irq_ack`, `cpu_lvl` is loaded from `ret_lvl`, including bit 3.
- R12: A write of 1 to bit k at address 1 sets the pending flag of source k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | NUM_SRC | Per-source request inputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_vec | output | 8 | Latched vector number |
| irq_lvl | output | 4 | Latched new priority level |
| irq_ack | input | 1 | Processor takes the interrupt |
| irq_ret | input | 1 | Processor returns from the interrupt |
| ret_lvl | input | 4 | Level to restore on return |
| cpu_lvl | output | 4 | Current processor priority level |
| saved_lvl | output | 4 | Level held before the last acknowledge |

## Verification
Two events can meet in a single cycle: a peripheral request setting a flag, and a software write clearing that same flag. The bench provokes this by driving `src_req` and a write-1-to-clear at address 0 on the same clock edge, then reads the flag back at address 0. The flag must still be set. A second, lone clear must then remove it. A further collision, between `irq_ack` and the registered request, is checked by confirming that the request is low in the cycle after the acknowledge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 4;
  localparam int PRIO_W   = 3;
  localparam int LVL_W    = 4;
  localparam int VEC_W    = 8;
  localparam int VEC_BASE = 8;
  localparam int SLOT_W   = 4;
  localparam int SLOTS    = DATA_W / SLOT_W;

  localparam logic [ADDR_W-1:0] A_FLAG   = 4'd0;
  localparam logic [ADDR_W-1:0] A_FSET   = 4'd1;
  localparam logic [ADDR_W-1:0] A_EN     = 4'd2;
  localparam logic [ADDR_W-1:0] A_PRIO   = 4'd3;
  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd8;
  localparam logic [ADDR_W-1:0] A_LVL    = 4'd9;
  localparam logic [ADDR_W-1:0] A_STAT   = 4'd10;

  typedef struct packed {
    logic [LVL_W-1:0] lvl;
    logic [VEC_W-1:0] vec;
  } irq_stat_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SRC-1:0]              src_req,
  input  logic                            reg_we,
  input  logic [ADDR_W-1:0]               reg_addr,
  input  logic [DATA_W-1:0]               reg_wdata,
  output logic [NUM_SRC-1:0]              flags,
  output logic [NUM_SRC-1:0]              enables,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]  prios
);
  logic wr_clr, wr_set, wr_en;

  assign wr_clr = reg_we && (reg_addr == A_FLAG);
  assign wr_set = reg_we && (reg_addr == A_FSET);
  assign wr_en  = reg_we && (reg_addr == A_EN);

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    localparam int WORD = k / SLOTS;
    localparam int LSB  = SLOT_W * (k % SLOTS);
    localparam logic [ADDR_W-1:0] PADDR = A_PRIO + ADDR_W'(WORD);

    logic              flag_d, flag_q;
    logic              en_d, en_q;
    logic [PRIO_W-1:0] prio_d, prio_q;
    logic              prio_ce;

    assign prio_ce = reg_we && (reg_addr == PADDR);

    always_comb begin
      flag_d = flag_q;
      if (wr_clr && reg_wdata[k]) flag_d = 1'b0;
      if ((wr_set && reg_wdata[k]) || src_req[k]) flag_d = 1'b1;
      en_d   = wr_en   ? reg_wdata[k] : en_q;
      prio_d = prio_ce ? reg_wdata[LSB +: PRIO_W] : prio_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q <= 1'b0;
        en_q   <= 1'b0;
        prio_q <= '0;
      end else begin
        flag_q <= flag_d;
        en_q   <= en_d;
        prio_q <= prio_d;
      end
    end

    assign flags[k]   = flag_q;
    assign enables[k] = en_q;
    assign prios[k]   = prio_q;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]             flags,
  input  logic [NUM_SRC-1:0]             enables,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prios,
  output logic                           found,
  output logic [IDX_W-1:0]               win_idx,
  output logic [PRIO_W-1:0]              win_prio
);
  logic [NUM_SRC-1:0] elig;

  assign elig = flags & enables;

  // Strict compare keeps the lowest index on ties and drops priority 0.
  always_comb begin
    found    = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (prios[i] > win_prio)) begin
        found    = 1'b1;
        win_idx  = IDX_W'(i);
        win_prio = prios[i];
      end
    end
  end
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              found,
  input  logic [IDX_W-1:0]  win_idx,
  input  logic [PRIO_W-1:0] win_prio,
  input  logic              gie,
  input  logic              nest_dis,
  input  logic              ack,
  input  logic              ret,
  input  logic [LVL_W-1:0]  ret_lvl,
  input  logic              sw_lvl_we,
  input  logic [PRIO_W-1:0] sw_lvl,
  output logic              req,
  output irq_stat_t         stat,
  output logic [LVL_W-1:0]  cpu_lvl,
  output logic [LVL_W-1:0]  saved_lvl
);
  localparam logic [LVL_W-1:0] NEST_LVL = 4'd7;

  logic             req_d, req_q, take;
  irq_stat_t        stat_d, stat_q;
  logic [LVL_W-1:0] cpu_d, cpu_q, saved_d, saved_q, new_lvl;

  assign new_lvl = {1'b0, win_prio};
  assign take    = found && gie && (new_lvl > cpu_q);

  always_comb begin
    req_d   = take && !ack;
    stat_d  = stat_q;
    cpu_d   = cpu_q;
    saved_d = saved_q;
    if (take) begin
      stat_d.vec = VEC_W'(VEC_BASE) + VEC_W'(win_idx);
      stat_d.lvl = new_lvl;
    end
    if (ack) begin
      saved_d = cpu_q;
      cpu_d   = (nest_dis && (stat_q.lvl < NEST_LVL)) ? NEST_LVL : stat_q.lvl;
    end else if (ret) begin
      cpu_d = ret_lvl;
    end else if (sw_lvl_we) begin
      cpu_d = {cpu_q[LVL_W-1], sw_lvl};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      stat_q  <= '0;
      cpu_q   <= '0;
      saved_q <= '0;
    end else begin
      req_q   <= req_d;
      stat_q  <= stat_d;
      cpu_q   <= cpu_d;
      saved_q <= saved_d;
    end
  end

  assign req       = req_q;
  assign stat      = stat_q;
  assign cpu_lvl   = cpu_q;
  assign saved_lvl = saved_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               reg_we,
  input  logic [3:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               irq_req,
  output logic [7:0]         irq_vec,
  output logic [3:0]         irq_lvl,
  input  logic               irq_ack,
  input  logic               irq_ret,
  input  logic [3:0]         ret_lvl,
  output logic [3:0]         cpu_lvl,
  output logic [3:0]         saved_lvl
);
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int NUM_PR = (NUM_SRC + SLOTS - 1) / SLOTS;

  logic                           rst_n_s;
  logic [NUM_SRC-1:0]             flags, enables;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prios;
  logic                           found;
  logic [IDX_W-1:0]               win_idx;
  logic [PRIO_W-1:0]              win_prio;
  irq_stat_t                      stat;
  logic                           gie_q, gie_d, nest_q, nest_d, ctrl_ce;
  logic [NUM_PR-1:0][DATA_W-1:0]  prio_words;

  irq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  irq_src_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk(clk), .rst_n(rst_n_s), .src_req(src_req),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .flags(flags), .enables(enables), .prios(prios)
  );

  irq_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .flags(flags), .enables(enables), .prios(prios),
    .found(found), .win_idx(win_idx), .win_prio(win_prio)
  );

  irq_level_ctrl #(.NUM_SRC(NUM_SRC)) u_lvl (
    .clk(clk), .rst_n(rst_n_s), .found(found), .win_idx(win_idx),
    .win_prio(win_prio), .gie(gie_q), .nest_dis(nest_q),
    .ack(irq_ack), .ret(irq_ret), .ret_lvl(ret_lvl),
    .sw_lvl_we(reg_we && (reg_addr == A_LVL)), .sw_lvl(reg_wdata[PRIO_W-1:0]),
    .req(irq_req), .stat(stat), .cpu_lvl(cpu_lvl), .saved_lvl(saved_lvl)
  );

  // Control register
  assign ctrl_ce = reg_we && (reg_addr == A_CTRL);

  always_comb begin
    gie_d  = ctrl_ce ? reg_wdata[0] : gie_q;
    nest_d = ctrl_ce ? reg_wdata[1] : nest_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      gie_q  <= 1'b0;
      nest_q <= 1'b0;
    end else begin
      gie_q  <= gie_d;
      nest_q <= nest_d;
    end
  end

  // Priority read-back words
  for (genvar w = 0; w < NUM_PR; w++) begin : g_pw
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      if (w * SLOTS + s < NUM_SRC) begin : g_used
        assign prio_words[w][SLOT_W*s +: SLOT_W] = {1'b0, prios[w*SLOTS+s]};
      end else begin : g_empty
        assign prio_words[w][SLOT_W*s +: SLOT_W] = '0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_FLAG, A_FSET: reg_rdata = DATA_W'(flags);
      A_EN:           reg_rdata = DATA_W'(enables);
      A_CTRL:         reg_rdata = {30'd0, nest_q, gie_q};
      A_LVL:          reg_rdata = DATA_W'(cpu_lvl);
      A_STAT:         reg_rdata = DATA_W'(stat);
      default: begin
        for (int w = 0; w < NUM_PR; w++)
          if (reg_addr == A_PRIO + ADDR_W'(w)) reg_rdata = prio_words[w];
      end
    endcase
  end

  assign irq_vec = stat.vec;
  assign irq_lvl = stat.lvl;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic                 clk,
  input logic                 rst_n_s,
  input logic                 reg_we,
  input logic [3:0]           reg_addr,
  input logic [NUM_SRC-1:0]   flags,
  input logic [NUM_SRC-1:0]   enables,
  input logic                 found,
  input logic [IDX_W-1:0]     win_idx,
  input logic                 irq_req,
  input logic [7:0]           irq_vec,
  input logic [3:0]           irq_lvl,
  input logic                 irq_ack,
  input logic                 irq_ret,
  input logic [3:0]           ret_lvl,
  input logic [3:0]           cpu_lvl,
  input logic                 nest_q
);
  assert_flag_hold_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    $past(!(reg_we && reg_addr == A_FLAG)) |-> ((flags & $past(flags)) == $past(flags)));

  assert_winner_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    found |-> (enables[win_idx] && flags[win_idx]));

  assert_vec_range_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_req |-> ((irq_vec >= 8'(VEC_BASE)) && (irq_vec < 8'(VEC_BASE + NUM_SRC)) && (irq_lvl != 4'd0)));

  assert_sw_bit3_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_we && reg_addr == A_LVL && !irq_ack && !irq_ret) |=> (cpu_lvl[3] == $past(cpu_lvl[3])));

  assert_ack_drop_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_ack |=> !irq_req);

  assert_ack_level_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (irq_ack && !nest_q) |=> (cpu_lvl == $past(irq_lvl)));

  assert_nest_level_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (irq_ack && nest_q) |=> (cpu_lvl >= 4'd7));

  assert_ret_level_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (irq_ret && !irq_ack) |=> (cpu_lvl == $past(ret_lvl)));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .reg_we(reg_we), .reg_addr(reg_addr),
  .flags(flags), .enables(enables), .found(found), .win_idx(win_idx),
  .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl),
  .irq_ack(irq_ack), .irq_ret(irq_ret), .ret_lvl(ret_lvl),
  .cpu_lvl(cpu_lvl), .nest_q(nest_q)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] src_req;
  logic         reg_we;
  logic [3:0]   reg_addr;
  logic [31:0]  reg_wdata;
  logic [31:0]  reg_rdata;
  logic         irq_req;
  logic [7:0]   irq_vec;
  logic [3:0]   irq_lvl;
  logic         irq_ack, irq_ret;
  logic [3:0]   ret_lvl, cpu_lvl, saved_lvl;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  prio_irq_ctrl #(.NUM_SRC(N)) dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl),
    .irq_ack(irq_ack), .irq_ret(irq_ret), .ret_lvl(ret_lvl),
    .cpu_lvl(cpu_lvl), .saved_lvl(saved_lvl)
  );

  typedef struct packed {
    logic [15:0] en;
    logic [15:0] pend;
    logic [63:0] prio;
    logic [2:0]  lvl;
    logic        req;
    logic [7:0]  vec;
    logic [3:0]  nlvl;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{en:16'h0001, pend:16'h0001, prio:64'h3,                   lvl:3'd0, req:1'b1, vec:8'd8,  nlvl:4'd3},
    '{en:16'h0006, pend:16'h0006, prio:64'h550,                 lvl:3'd0, req:1'b1, vec:8'd9,  nlvl:4'd5},
    '{en:16'h8003, pend:16'h8003, prio:64'h6000_0000_0000_0042, lvl:3'd1, req:1'b1, vec:8'd23, nlvl:4'd6},
    '{en:16'h0001, pend:16'h0003, prio:64'h72,                  lvl:3'd0, req:1'b1, vec:8'd8,  nlvl:4'd2},
    '{en:16'h0001, pend:16'h0001, prio:64'h4,                   lvl:3'd4, req:1'b0, vec:8'd0,  nlvl:4'd0},
    '{en:16'h0001, pend:16'h0001, prio:64'h4,                   lvl:3'd3, req:1'b1, vec:8'd8,  nlvl:4'd4},
    '{en:16'h0010, pend:16'h0010, prio:64'h0,                   lvl:3'd0, req:1'b0, vec:8'd0,  nlvl:4'd0},
    '{en:16'h0200, pend:16'h0200, prio:64'h70_0000_0000,        lvl:3'd6, req:1'b1, vec:8'd17, nlvl:4'd7}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse_src(input logic [N-1:0] m);
    @(negedge clk);
    src_req = m;
    @(negedge clk);
    src_req = '0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; src_req = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    irq_ack = 1'b0; irq_ret = 1'b0; ret_lvl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Reset state
    check("reset irq_req", 32'(irq_req), 32'd0);
    check("reset cpu_lvl", 32'(cpu_lvl), 32'd0);
    rd(4'd0, d); check("reset flags R1", d, 32'd0);
    rd(4'd2, d); check("reset enables R2", d, 32'd0);

    // Vector table: R2 R4 R5 R6
    wr(4'd8, 32'h1);
    for (int i = 0; i < NV; i++) begin
      wr(4'd0, 32'hFFFF);
      wr(4'd2, 32'(VECS[i].en));
      wr(4'd3, VECS[i].prio[31:0]);
      wr(4'd4, VECS[i].prio[63:32]);
      wr(4'd9, 32'(VECS[i].lvl));
      pulse_src(VECS[i].pend);
      check($sformatf("vec%0d irq_req R4 R6", i), 32'(irq_req), 32'(VECS[i].req));
      if (VECS[i].req) begin
        check($sformatf("vec%0d irq_vec R4 R5", i), 32'(irq_vec), 32'(VECS[i].vec));
        check($sformatf("vec%0d irq_lvl R5", i), 32'(irq_lvl), 32'(VECS[i].nlvl));
        rd(4'd10, d);
        check($sformatf("vec%0d status R5", i), d, {20'd0, VECS[i].nlvl, VECS[i].vec});
      end
    end

    // R3: priority layout read-back
    wr(4'd3, 32'hFFFF_FFFF);
    rd(4'd3, d); check("prio word0 R3", d, 32'h7777_7777);
    wr(4'd4, 32'h0000_0A50);
    rd(4'd4, d); check("prio word1 R3", d, 32'h0000_0250);

    // R1: set and clear in the same cycle, then clear alone
    wr(4'd0, 32'hFFFF);
    @(negedge clk);
    src_req = 16'h0004; reg_we = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h4;
    @(negedge clk);
    src_req = '0; reg_we = 1'b0;
    repeat (3) @(negedge clk);
    rd(4'd0, d); check("set beats clear R1", d, 32'h4);
    wr(4'd0, 32'h4);
    rd(4'd0, d); check("clear alone R1", d, 32'h0);

    // R12: software set
    wr(4'd1, 32'h20);
    rd(4'd0, d); check("sw set R12", d, 32'h20);
    wr(4'd0, 32'h20);

    // R7: global enable off
    wr(4'd2, 32'h1); wr(4'd3, 32'h5); wr(4'd4, 32'h0); wr(4'd9, 32'h0);
    wr(4'd8, 32'h0);
    pulse_src(16'h1);
    @(negedge clk);
    check("gie off R7", 32'(irq_req), 32'd0);
    wr(4'd8, 32'h1);
    @(negedge clk);
    check("gie on R7", 32'(irq_req), 32'd1);

    // R9: acknowledge
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    check("ack cpu_lvl R9", 32'(cpu_lvl), 32'd5);
    check("ack saved_lvl R9", 32'(saved_lvl), 32'd0);
    check("ack drops req R9", 32'(irq_req), 32'd0);
    @(negedge clk);
    check("req stays low R9", 32'(irq_req), 32'd0);

    // R11: return
    ret_lvl = 4'd1; irq_ret = 1'b1;
    @(negedge clk);
    irq_ret = 1'b0;
    check("ret restore R11", 32'(cpu_lvl), 32'd1);
    @(negedge clk);
    check("req after ret R6", 32'(irq_req), 32'd1);

    // R10: nesting disabled
    wr(4'd8, 32'h3);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    check("nest cpu_lvl R10", 32'(cpu_lvl), 32'd7);
    check("nest saved R10", 32'(saved_lvl), 32'd1);

    // R8: bit 3 only from hardware
    ret_lvl = 4'd8; irq_ret = 1'b1;
    @(negedge clk);
    irq_ret = 1'b0;
    wr(4'd9, 32'hF3);
    rd(4'd9, d); check("sw keeps bit3 R8", d, 32'hB);
    wr(4'd3, 32'h7);
    repeat (2) @(negedge clk);
    check("level 11 masks prio 7 R6", 32'(irq_req), 32'd0);
    ret_lvl = 4'd0; irq_ret = 1'b1;
    @(negedge clk);
    irq_ret = 1'b0;
    wr(4'd9, 32'h8);
    rd(4'd9, d); check("sw cannot set bit3 R8", d, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule